// File: doc/BRIEF.md
# Demote-Only Region Cache Mode Table

This block holds one cache mode for each of 16 memory regions. A lookup port takes an address and returns the mode of the region that owns it. The region is chosen by the four most significant address bits. A request port asks to change the mode of one region. A change is accepted only when it moves the region to a strictly lower mode. After a region has been lowered, only reset can raise it again, and reset returns every region to write-back.

An accepted demotion is not applied at once. The block first asks an attached cache maintenance engine to clean and invalidate the whole cache, and waits for that engine's done acknowledge. Only then does the new mode take effect, together with a success status. A rejected request produces a fail status and changes nothing. No maintenance is requested for it. While a demotion waits for the engine, the request port stalls.

Top module: `region_cache_mode`

## Requirements
- R1: Modes are 2-bit codes: 0 non-cacheable, 2 write-through, 3 write-back. Code 1 is never stored and never returned on `lk_mode`.
- R2: After reset, every region reads back as write-back (3) and `stat_valid` and `clr_req` are low.
- R3: Request select value s targets region 15-s. A lookup address whose top four bits equal r reads region r. The other address bits have no effect.
- R4: A request whose new mode is greater than or equal to the region's current mode gives, in the cycle after acceptance, `stat_valid`=1 with `stat_ok`=0. It changes no mode and does not raise `clr_req`.
- R5: A request carrying code 1 is rejected in the same way as R4.
- R6: An accepted demotion raises `clr_req` in the cycle after acceptance. `clr_req` stays high until `clr_done` is sampled high. The region keeps its old mode during this time.
- R7: In the cycle after `clr_done` is sampled with `clr_req` high, `clr_req` is low, `stat_valid`=1 with `stat_ok`=1, and `lk_mode` already shows the new mode for a lookup of that region presented in the done cycle.
- R8: `req_ready` is low while a demotion is pending. Requests driven during that time are ignored and change no region.
- R9: `lk_mode` is registered. It gives the mode of the region addressed in the previous cycle.
- R10: A region's mode never increases except through reset. Reset asserted mid-run restores every region to write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Demotion request present |
| req_ready | output | 1 | Block can accept a request |
| req_sel | input | 4 | Reversed region select (s names region 15-s) |
| req_mode | input | 2 | Requested new mode code |
| stat_valid | output | 1 | One-cycle status pulse |
| stat_ok | output | 1 | Status: 1 applied, 0 rejected |
| clr_req | output | 1 | Clean-and-invalidate-all request to maintenance engine |
| clr_done | input | 1 | Maintenance engine done acknowledge |
| lk_addr | input | ADDR_W | Lookup address |
| lk_mode | output | 2 | Mode of the looked-up region |

## Verification
A corrupted region entry shows on `lk_mode` one cycle after that region is addressed. The bench scans every region after each request sequence, so a stray write or a raise is seen within the next scan. A controller that applies a change early, or skips the maintenance handshake, shows a new mode while `clr_req` is still high, or gives a success pulse without a preceding handshake. A controller that lets a stalled request through shows a changed neighbouring region in the lookup that follows.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  typedef enum logic [1:0] {
    MODE_NC   = 2'd0,
    MODE_RSVD = 2'd1,
    MODE_WT   = 2'd2,
    MODE_WB   = 2'd3
  } cmode_e;

  localparam logic [1:0] MODE_RESET = MODE_WB;
endpackage

// File: rtl/rcm_mode_file.sv
module rcm_mode_file #(
  parameter int REG_BITS = 4,
  localparam int NREG = 1 << REG_BITS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [REG_BITS-1:0]        wr_idx,
  input  logic [1:0]                 wr_mode,
  input  logic [REG_BITS-1:0]        rd_idx,
  output logic [1:0]                 rd_mode,
  output logic [NREG-1:0][1:0]       modes
);
  import rcm_pkg::*;

  logic [NREG-1:0][1:0] mode_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        mode_q[i] <= MODE_RESET;
      else if (wr_en && wr_idx == REG_BITS'(i))
        mode_q[i] <= wr_mode;
    end

    p_no_raise_r10: assert property (@(posedge clk) disable iff (rst)
      !(mode_q[i] > $past(mode_q[i])));
    p_no_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
      mode_q[i] != MODE_RSVD);
  end

  assign rd_mode = mode_q[rd_idx];
  assign modes   = mode_q;
endmodule

// File: rtl/rcm_lookup.sv
module rcm_lookup #(
  parameter int REG_BITS = 4,
  localparam int NREG = 1 << REG_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_BITS-1:0]   lk_region,
  input  logic [NREG-1:0][1:0]  modes,
  input  logic                  wr_en,
  input  logic [REG_BITS-1:0]   wr_idx,
  input  logic [1:0]            wr_mode,
  output logic [1:0]            lk_mode
);
  import rcm_pkg::*;

  logic fwd;
  assign fwd = wr_en && (wr_idx == lk_region);

  always_ff @(posedge clk) begin
    if (rst)
      lk_mode <= MODE_RESET;
    else
      lk_mode <= fwd ? wr_mode : modes[lk_region];
  end
endmodule

// File: rtl/rcm_demote_ctrl.sv
module rcm_demote_ctrl #(
  parameter int REG_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [REG_BITS-1:0]  req_sel,
  input  logic [1:0]           req_mode,
  output logic [REG_BITS-1:0]  rd_idx,
  input  logic [1:0]           rd_mode,
  output logic                 stat_valid,
  output logic                 stat_ok,
  output logic                 clr_req,
  input  logic                 clr_done,
  output logic                 wr_en,
  output logic [REG_BITS-1:0]  wr_idx,
  output logic [1:0]           wr_mode
);
  import rcm_pkg::*;

  typedef enum logic {ST_IDLE, ST_PEND} st_e;
  st_e st;
  logic [REG_BITS-1:0] pend_idx;
  logic [1:0]          pend_mode;
  logic                lower_ok;

  assign rd_idx    = ~req_sel;
  assign lower_ok  = (req_mode != MODE_RSVD) && (req_mode < rd_mode);
  assign req_ready = (st == ST_IDLE);
  assign wr_en     = (st == ST_PEND) && clr_done;
  assign wr_idx    = pend_idx;
  assign wr_mode   = pend_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      stat_valid <= 1'b0;
      stat_ok    <= 1'b0;
      clr_req    <= 1'b0;
      pend_idx   <= '0;
      pend_mode  <= MODE_RESET;
    end else begin
      stat_valid <= 1'b0;
      stat_ok    <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          if (lower_ok) begin
            st        <= ST_PEND;
            clr_req   <= 1'b1;
            pend_idx  <= rd_idx;
            pend_mode <= req_mode;
          end else begin
            stat_valid <= 1'b1;
          end
        end
        ST_PEND: if (clr_done) begin
          st         <= ST_IDLE;
          clr_req    <= 1'b0;
          stat_valid <= 1'b1;
          stat_ok    <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_clr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !clr_done) |=> clr_req);
  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> !req_ready);
  p_ok_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_ok) |-> $past(clr_req && clr_done));
  p_fail_no_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !stat_ok) |-> !clr_req);
endmodule

// File: rtl/region_cache_mode.sv
module region_cache_mode #(
  parameter int ADDR_W   = 32,
  parameter int REG_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [REG_BITS-1:0]  req_sel,
  input  logic [1:0]           req_mode,
  output logic                 stat_valid,
  output logic                 stat_ok,
  output logic                 clr_req,
  input  logic                 clr_done,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic [1:0]           lk_mode
);
  localparam int NREG = 1 << REG_BITS;

  logic [REG_BITS-1:0]  rd_idx, wr_idx, lk_region;
  logic [1:0]           rd_mode, wr_mode;
  logic                 wr_en;
  logic [NREG-1:0][1:0] modes;

  assign lk_region = lk_addr[ADDR_W-1 -: REG_BITS];
  logic unused_addr_lo;
  assign unused_addr_lo = ^lk_addr[ADDR_W-REG_BITS-1:0];

  rcm_demote_ctrl #(.REG_BITS(REG_BITS)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_mode(req_mode),
    .rd_idx(rd_idx), .rd_mode(rd_mode),
    .stat_valid(stat_valid), .stat_ok(stat_ok),
    .clr_req(clr_req), .clr_done(clr_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode)
  );

  rcm_mode_file #(.REG_BITS(REG_BITS)) u_file (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode),
    .rd_idx(rd_idx), .rd_mode(rd_mode), .modes(modes)
  );

  rcm_lookup #(.REG_BITS(REG_BITS)) u_lookup (
    .clk(clk), .rst(rst),
    .lk_region(lk_region), .modes(modes),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode),
    .lk_mode(lk_mode)
  );

  p_change_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
    (modes != $past(modes)) |-> $past(clr_req && clr_done));
endmodule

// File: tb/sim_region_cache_mode.sv
`timescale 1ns/1ps
module sim_region_cache_mode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sel = '0;
  logic [1:0]  req_mode = '0;
  logic        stat_valid, stat_ok, clr_req;
  logic        clr_done = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_mode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int expm [16];

  always #4 clk = ~clk;

  region_cache_mode u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_mode(req_mode), .stat_valid(stat_valid),
    .stat_ok(stat_ok), .clr_req(clr_req), .clr_done(clr_done),
    .lk_addr(lk_addr), .lk_mode(lk_mode)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  function automatic logic [31:0] addr_of(input int r);
    return {r[3:0], 28'($urandom())};
  endfunction

  // R3/R9: lookup of region r, one-cycle registered result
  task automatic look(input int r, input string tag);
    lk_addr = addr_of(r);
    @(posedge clk); @(negedge clk);
    chk(lk_mode == expm[r][1:0], tag, lk_mode, expm[r]);
  endtask

  task automatic scan_all(input string tag);
    for (int r = 0; r < 16; r++) look(r, tag);
  endtask

  task automatic do_req(input int sel, input int m, input int lat);
    int region;
    bit ok;
    region = 15 - sel;
    ok = (m != 1) && (m < expm[region]);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel[3:0]; req_mode = m[1:0];
    lk_addr = addr_of(region);
    chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      chk(stat_valid && !stat_ok, (m == 1) ? "R5 rsvd rejected" : "R4 non-lowering rejected",
          {stat_valid, stat_ok}, 2);
      chk(clr_req == 1'b0, "R4 no clear on reject", clr_req, 0);
      chk(lk_mode == expm[region][1:0], "R4 mode unchanged", lk_mode, expm[region]);
    end else begin
      chk(clr_req && !stat_valid, "R6 clear raised", {clr_req, stat_valid}, 2);
      for (int k = 0; k < lat; k++) begin
        chk(req_ready == 1'b0, "R8 stalled while pending", req_ready, 0);
        req_valid = 1'b1; req_sel = 4'(sel + 1); req_mode = 2'd0;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(clr_req == 1'b1, "R6 clear held", clr_req, 1);
        chk(lk_mode == expm[region][1:0], "R6 old mode while pending", lk_mode, expm[region]);
      end
      clr_done = 1'b1;
      @(posedge clk); @(negedge clk);
      clr_done = 1'b0;
      expm[region] = m;
      chk(stat_valid && stat_ok, "R7 success pulse", {stat_valid, stat_ok}, 3);
      chk(clr_req == 1'b0, "R7 clear dropped", clr_req, 0);
      chk(lk_mode == m[1:0], "R7 new mode visible", lk_mode, m);
      look(15 - ((sel + 1) % 16), "R8 stalled request ignored");
    end
  endtask

  initial begin
    int seq [7] = '{3, 1, 2, 2, 3, 0, 0};
    for (int r = 0; r < 16; r++) expm[r] = 3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!stat_valid && !clr_req, "R2 reset outputs", {stat_valid, clr_req}, 0);
    rst = 1'b0;
    scan_all("R2 reset all write-back");

    // R3: demote select 0 only, region 15 changes, region 0 does not
    do_req(0, 2, 1);
    look(15, "R3 reversed select hits region 15");
    look(0, "R3 region 0 untouched");

    for (int s = 0; s < 16; s++) begin
      for (int j = 0; j < 7; j++) do_req(s, seq[j], (s + j) % 4);
      scan_all("R10 scan after sequence");
    end
    for (int s = 0; s < 16; s++) do_req(s, 1, 0); // R5 on all-zero table

    // R10: mid-run reset restores write-back
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 16; r++) expm[r] = 3;
    scan_all("R10 reset restores");

    // direct 3 -> 0 demotions, then raises refused
    for (int s = 0; s < 16; s += 3) begin
      do_req(s, 0, 2);
      do_req(s, 2, 0);
      do_req(s, 3, 0);
    end
    scan_all("R1 final scan");
    finish_run();
  end
endmodule